// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the command front end of a serial flash device model that acts as an SPI slave. While chip select is low it shifts in bytes from the serial data input. It recognises four commands: set write enable, erase one block, erase the whole chip, and program a page. When chip select is released it decides whether the command is legal. A command is legal only if the release falls exactly after a whole byte, the command has the right length, the write-enable latch is set, no self-timed cycle is running and the target is not locked by the protect bits.

An accepted erase or program command sends a one-cycle start request, with its kind and address, to the memory array that sits beside this block. The block then runs a self-timed busy cycle whose length, in system clock cycles, is a parameter for each kind of operation. While a page program frame is being received, its data bytes stream into a page buffer at indices that wrap within the page. The write-in-progress and write-enable-latch status bits are outputs.

The serial pins are sampled on the system clock, which must run several times faster than the serial clock.

Top module: `flash_cmd_seq`

## Requirements
- R1: An erase or program command starts only if the write-enable latch is 1 at the moment chip select rises; otherwise nothing starts and the latch keeps its value.
- R2: A frame is discarded unless chip select rises after a whole number of bytes and the byte count fits the command: write enable and chip erase take exactly 1 byte, block erase exactly 4 (opcode and a 24-bit address, most significant byte first), page program 5 or more.
- R3: An accepted block erase reports kind 1 and an address with the low 16 bits cleared, so every address in a 64 KiB block names that block.
- R4: Protect input `lock_lvl` = 0 locks nothing. A nonzero value L locks the top 2^(L-1) of the 32 blocks, and all blocks once that span reaches 32. Chip erase (kind 2) starts only when `lock_lvl` is 0. Block erase and page program (kind 3) are refused when the addressed block, address bits 20:16, is locked.
- R5: The start request `op_start` pulses for one cycle, in the cycle after the clock edge that first samples chip select high. `wip` goes to 1 in that same cycle and stays at 1 for exactly BE_CYCLES, CE_CYCLES or PP_CYCLES clock cycles.
- R6: At the end of the busy cycle `wip` returns to 0 and `wel` is cleared in the same cycle.
- R7: An erase or program command whose chip select rises while `wip` is 1 is ignored, and no page buffer write happens while `wip` is 1.
- R8: In a page program frame, data byte k (k = 0 for the first byte after the address) is written to page buffer index (address[7:0] + k) mod 256 as the frame arrives, whether or not the command is later accepted.
- R9: Opcodes: 0x06 sets `wel` (this is allowed while busy); 0xD8 is block erase; 0xC7 and 0x60 are chip erase; 0x02 is page program. Bits are taken on rising `sclk` while `cs_n` is low, most significant bit first, and the bit count restarts whenever `cs_n` is high.
- R10: After reset `wip`, `wel`, `op_start`, `pb_we` and `pb_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than sclk |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| lock_lvl | input | 4 | Protect level |
| op_start | output | 1 | One-cycle start request to the array |
| op_kind | output | 2 | 1 block erase, 2 chip erase, 3 page program |
| op_addr | output | 24 | Block base or page program start address |
| pb_clr | output | 1 | Clear the page buffer before new data |
| pb_we | output | 1 | Page buffer write strobe |
| pb_idx | output | 8 | Page buffer index |
| pb_wdata | output | 8 | Page buffer write data |
| wip | output | 1 | Write in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The hardest case to reach is a fully formed, write-enabled program command that arrives while a self-timed cycle is running. A whole frame must fit inside one busy window. The stimulus therefore starts a chip erase, whose cycle count is the longest, and then sends a write enable and a five-byte page program inside that window. The bench expects no start pulse and no page buffer write. A second hard case is chip select released part way through a byte after a correct prefix. Frames are cut a few bits into the next byte to reach it.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int ADDR_W = 24;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OPC_SET_WE   = 8'h06;
    localparam logic [7:0] OPC_BLK_ERS  = 8'hD8;
    localparam logic [7:0] OPC_CHIP_A   = 8'hC7;
    localparam logic [7:0] OPC_CHIP_B   = 8'h60;
    localparam logic [7:0] OPC_PAGE_WR  = 8'h02;

    typedef enum logic [1:0] {
        OP_NONE      = 2'd0,
        OP_BLK_ERASE = 2'd1,
        OP_CHIP_ERASE= 2'd2,
        OP_PAGE_PROG = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_SET_WE,
        CMD_BLK,
        CMD_CHIP,
        CMD_PAGE,
        CMD_OTHER
    } cmd_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [2:0]        nbytes;
        logic [ADDR_W-1:0] addr;
    } frame_t;

    function automatic cmd_e decode_opcode(input logic [7:0] opc);
        case (opc)
            OPC_SET_WE:             return CMD_SET_WE;
            OPC_BLK_ERS:            return CMD_BLK;
            OPC_CHIP_A, OPC_CHIP_B: return CMD_CHIP;
            OPC_PAGE_WR:            return CMD_PAGE;
            default:                return CMD_OTHER;
        endcase
    endfunction

    // Length rule per command (R2)
    function automatic logic frame_len_ok(input cmd_e c, input logic [2:0] n);
        case (c)
            CMD_SET_WE, CMD_CHIP: return n == 3'd1;
            CMD_BLK:              return n == 3'd4;
            CMD_PAGE:             return n >= 3'd5;
            default:              return 1'b0;
        endcase
    endfunction

    // Top 2^(lvl-1) blocks are locked (R4)
    function automatic logic blk_locked(input logic [3:0] lvl,
                                        input int unsigned blk,
                                        input int unsigned nblk);
        int unsigned span;
        if (lvl == 4'd0) return 1'b0;
        span = 1 << (lvl - 4'd1);
        if (span >= nblk) return 1'b1;
        return blk >= (nblk - span);
    endfunction

endpackage

// File: rtl/flash_spi_shift.sv
module flash_spi_shift
    import flash_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             si,
    output logic             byte_vld,
    output logic [BYTE_W-1:0] byte_q,
    output logic             on_boundary,
    output logic             cs_rise,
    output logic             cs_fall
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic             sclk_q;
    logic             cs_q;
    logic [BIT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0] shreg;
    logic             sclk_rise;

    assign sclk_rise   = sclk & ~sclk_q & ~cs_n;
    assign on_boundary = (bit_cnt == '0);
    assign cs_rise     = cs_n & ~cs_q;
    assign cs_fall     = ~cs_n & cs_q;

    // Mode 0, MSB first, count restarts while deselected (R9)
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            sclk_q   <= sclk;
            cs_q     <= cs_n;
            byte_vld <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shreg   <= {shreg[BYTE_W-3:0], si};
                bit_cnt <= bit_cnt + BIT_W'(1);
                if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
                    byte_vld <= 1'b1;
                    byte_q   <= {shreg, si};
                end
            end
        end
    end

endmodule

// File: rtl/flash_frame_collect.sv
module flash_frame_collect
    import flash_seq_pkg::*;
#(
    parameter int PAGE_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_q,
    input  logic              busy,
    output frame_t            frame,
    output logic              pb_clr,
    output logic              pb_we,
    output logic [PAGE_W-1:0] pb_idx,
    output logic [BYTE_W-1:0] pb_wdata
);
    cmd_e              cmd_r;
    logic [2:0]        nb_r;
    logic [ADDR_W-1:0] addr_r;
    logic [ADDR_W-1:0] addr_nx;
    logic [PAGE_W-1:0] pb_ptr;

    assign addr_nx = {addr_r[ADDR_W-BYTE_W-1:0], byte_q};

    always_comb begin
        frame.cmd    = cmd_r;
        frame.nbytes = nb_r;
        frame.addr   = addr_r;
    end

    always_ff @(posedge clk) begin
        if (rst || cs_fall) begin
            cmd_r  <= CMD_NONE;
            nb_r   <= '0;
            addr_r <= '0;
        end else if (byte_vld) begin
            if (nb_r != 3'd7) nb_r <= nb_r + 3'd1;
            case (nb_r)
                3'd0:             cmd_r  <= decode_opcode(byte_q);
                3'd1, 3'd2, 3'd3: addr_r <= addr_nx;
                default: ;
            endcase
        end
    end

    // Page data streams in with wrap inside the page (R8), never while busy (R7)
    always_ff @(posedge clk) begin
        if (rst) begin
            pb_clr   <= 1'b0;
            pb_we    <= 1'b0;
            pb_idx   <= '0;
            pb_wdata <= '0;
            pb_ptr   <= '0;
        end else begin
            pb_clr <= 1'b0;
            pb_we  <= 1'b0;
            if (byte_vld && cmd_r == CMD_PAGE) begin
                if (nb_r == 3'd3) begin
                    pb_ptr <= addr_nx[PAGE_W-1:0];
                    pb_clr <= ~busy;
                end else if (nb_r >= 3'd4) begin
                    pb_ptr   <= pb_ptr + PAGE_W'(1);
                    pb_we    <= ~busy;
                    pb_idx   <= pb_ptr;
                    pb_wdata <= byte_q;
                end
            end
        end
    end

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CNT_W = 9
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1)) && !load;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int BLK_SHIFT = 16,
    parameter int BLK_CNT   = 32,
    parameter int PAGE_W    = 8,
    parameter int BE_CYCLES = 40,
    parameter int CE_CYCLES = 300,
    parameter int PP_CYCLES = 25
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              si,
    input  logic [3:0]        lock_lvl,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic              pb_clr,
    output logic              pb_we,
    output logic [PAGE_W-1:0] pb_idx,
    output logic [BYTE_W-1:0] pb_wdata,
    output logic              wip,
    output logic              wel
);
    localparam int BLK_IDX_W = $clog2(BLK_CNT);
    localparam int MAX_CYC   = (BE_CYCLES > CE_CYCLES)
                             ? ((BE_CYCLES > PP_CYCLES) ? BE_CYCLES : PP_CYCLES)
                             : ((CE_CYCLES > PP_CYCLES) ? CE_CYCLES : PP_CYCLES);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [ADDR_W-1:0] BLK_MASK =
        ~((ADDR_W'(1) << BLK_SHIFT) - ADDR_W'(1));

    logic              byte_vld;
    logic [BYTE_W-1:0] byte_q;
    logic              on_boundary;
    logic              cs_rise;
    logic              cs_fall;
    frame_t            frame;
    logic              busy;
    logic              done;

    logic [BLK_IDX_W-1:0] blk_idx;
    logic                 locked;
    logic                 accept_frame;
    logic                 set_we;
    op_kind_e             l_kind;
    logic [ADDR_W-1:0]    l_addr;
    logic [CNT_W-1:0]     l_len;
    logic                 launch;

    flash_spi_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .si          (si),
        .byte_vld    (byte_vld),
        .byte_q      (byte_q),
        .on_boundary (on_boundary),
        .cs_rise     (cs_rise),
        .cs_fall     (cs_fall)
    );

    flash_frame_collect #(.PAGE_W(PAGE_W)) u_collect (
        .clk      (clk),
        .rst      (rst),
        .cs_fall  (cs_fall),
        .byte_vld (byte_vld),
        .byte_q   (byte_q),
        .busy     (busy),
        .frame    (frame),
        .pb_clr   (pb_clr),
        .pb_we    (pb_we),
        .pb_idx   (pb_idx),
        .pb_wdata (pb_wdata)
    );

    flash_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .load_val (l_len),
        .busy     (busy),
        .done     (done)
    );

    // Verdict at chip-select release (R1, R2, R4, R7)
    always_comb begin
        blk_idx      = frame.addr[BLK_SHIFT +: BLK_IDX_W];
        locked       = blk_locked(lock_lvl, 32'(blk_idx), BLK_CNT);
        accept_frame = cs_rise && on_boundary && frame_len_ok(frame.cmd, frame.nbytes);
        set_we       = accept_frame && frame.cmd == CMD_SET_WE;
        l_kind       = OP_NONE;
        l_addr       = '0;
        l_len        = '0;
        if (accept_frame && wel && !busy) begin
            case (frame.cmd)
                CMD_BLK: if (!locked) begin
                    l_kind = OP_BLK_ERASE;
                    l_addr = frame.addr & BLK_MASK;
                    l_len  = CNT_W'(BE_CYCLES);
                end
                CMD_CHIP: if (lock_lvl == 4'd0) begin
                    l_kind = OP_CHIP_ERASE;
                    l_len  = CNT_W'(CE_CYCLES);
                end
                CMD_PAGE: if (!locked) begin
                    l_kind = OP_PAGE_PROG;
                    l_addr = frame.addr;
                    l_len  = CNT_W'(PP_CYCLES);
                end
                default: ;
            endcase
        end
        launch = (l_kind != OP_NONE);
    end

    assign wip = busy;

    // Completion clears the latch and wins over a same-cycle write enable (R6)
    always_ff @(posedge clk) begin
        if (rst) begin
            op_start <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            wel      <= 1'b0;
        end else begin
            op_start <= launch;
            op_kind  <= l_kind;
            op_addr  <= l_addr;
            if (done)
                wel <= 1'b0;
            else if (set_we)
                wel <= 1'b1;
        end
    end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] lock_lvl,
    input logic       op_start,
    input logic [1:0] op_kind,
    input logic       wip,
    input logic       wel,
    input logic       pb_we
);
    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        op_start |-> $past(wel)); // R1
    AST_START_RAISES_WIP: assert property (@(posedge clk) disable iff (rst)
        op_start |-> wip); // R5
    AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> !wel); // R6
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !$past(wip)); // R7
    AST_CHIP_ERASE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_kind == 2'd2) |-> ($past(lock_lvl) == 4'd0)); // R4
    AST_NO_PB_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
        pb_we |-> !$past(wip)); // R7
endmodule

bind flash_cmd_seq flash_cmd_seq_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .lock_lvl (lock_lvl),
    .op_start (op_start),
    .op_kind  (op_kind),
    .wip      (wip),
    .wel      (wel),
    .pb_we    (pb_we)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;

    localparam int BE_N = 40;
    localparam int CE_N = 300;
    localparam int PP_N = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic [3:0]  lock_lvl = 4'd0;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [23:0] op_addr;
    logic        pb_clr;
    logic        pb_we;
    logic [7:0]  pb_idx;
    logic [7:0]  pb_wdata;
    logic        wip;
    logic        wel;

    always #2 clk = ~clk;

    flash_cmd_seq #(.BE_CYCLES(BE_N), .CE_CYCLES(CE_N), .PP_CYCLES(PP_N)) i_flash_cmd_seq (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si(si), .lock_lvl(lock_lvl),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .pb_clr(pb_clr), .pb_we(pb_we), .pb_idx(pb_idx), .pb_wdata(pb_wdata),
        .wip(wip), .wel(wel)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    int   m_cnt = 0;
    bit   m_wel = 0;
    bit   m_start = 0;
    int   m_kind = 0;
    int   m_addr = 0;
    bit   prev_cs = 1;
    logic [7:0] fr_bytes[$];
    int   fr_bits = 0;
    int   pb_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic bit prot(input int a);
        int blk;
        blk = (a >> 16) % 32;
        if (lock_lvl == 0) return 0;
        return (blk + (1 << (int'(lock_lvl) - 1))) >= 32;
    endfunction

    task automatic model_step();
        bit busy_pre;
        bit done;
        bit wen;
        int kind;
        int addr;
        int len;
        int nb;
        int a;
        logic [7:0] opc;
        if (rst) begin
            m_cnt = 0; m_wel = 0; m_start = 0; m_kind = 0; m_addr = 0;
            prev_cs = cs_n;
            return;
        end
        busy_pre = (m_cnt != 0);
        done = (m_cnt == 1);
        wen = 0; kind = 0; addr = 0; len = 0;
        if (cs_n && !prev_cs && (fr_bits % 8) == 0 && fr_bits > 0) begin
            nb = fr_bits / 8;
            opc = fr_bytes[0];
            a = (nb >= 4) ? int'({fr_bytes[1], fr_bytes[2], fr_bytes[3]}) : 0;
            if (opc == 8'h06 && nb == 1) wen = 1;
            if (m_wel && !busy_pre) begin
                if (opc == 8'hD8 && nb == 4 && !prot(a)) begin
                    kind = 1; addr = a & 32'hFF0000; len = BE_N;
                end
                if ((opc == 8'hC7 || opc == 8'h60) && nb == 1 && lock_lvl == 0) begin
                    kind = 2; addr = 0; len = CE_N;
                end
                if (opc == 8'h02 && nb >= 5 && !prot(a)) begin
                    kind = 3; addr = a; len = PP_N;
                end
            end
        end
        if (kind != 0) m_cnt = len;
        else if (m_cnt != 0) m_cnt--;
        if (done) m_wel = 0;
        else if (wen) m_wel = 1;
        m_start = (kind != 0);
        m_kind = kind;
        m_addr = addr;
        prev_cs = cs_n;
    endtask

    task automatic compare();
        int e;
        chk(wip == (m_cnt != 0), "R5 R6 wip", int'(wip), int'(m_cnt != 0));
        chk(wel == m_wel, "R1 R6 R9 wel", int'(wel), int'(m_wel));
        chk(op_start == m_start, "R5 op_start", int'(op_start), int'(m_start));
        if (m_start) begin
            chk(op_kind == m_kind[1:0], "R4 op_kind", int'(op_kind), m_kind);
            chk(op_addr == m_addr[23:0], "R3 op_addr", int'(op_addr), m_addr);
        end
        if (pb_we) begin
            if (pb_q.size() == 0) begin
                chk(0, "R7 R8 unexpected page write", int'({pb_idx, pb_wdata}), 0);
            end else begin
                e = pb_q.pop_front();
                chk({pb_idx, pb_wdata} == e[15:0], "R8 page write", int'({pb_idx, pb_wdata}), e);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // n whole bytes (first byte in the top of 'pk'), then 'extra' bits of 0xA5
    task automatic frame(input int n, input logic [63:0] pk, input int extra);
        logic [7:0] cur;
        int total;
        cs_n = 1'b0;
        fr_bytes = {};
        fr_bits = 0;
        tick(); tick();
        total = n * 8 + extra;
        for (int i = 0; i < total; i++) begin
            cur = (i / 8 < n) ? pk[8 * (n - 1 - i / 8) +: 8] : 8'hA5;
            si = cur[7 - (i % 8)];
            sclk = 1'b0;
            tick(); tick();
            sclk = 1'b1;
            tick();
            fr_bits++;
            if ((i % 8) == 7) begin
                fr_bytes.push_back(cur);
                if (i / 8 >= 4 && fr_bytes[0] == 8'h02 && m_cnt == 0)
                    pb_q.push_back({(fr_bytes[3] + 8'(i / 8 - 4)), cur});
            end
            tick();
        end
        sclk = 1'b0;
        si = 1'b0;
        tick(); tick(); tick();
        cs_n = 1'b1;
        tick(); tick();
    endtask

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();
        chk(!wip && !wel && !op_start && !pb_we && !pb_clr, "R10 reset state",
            int'({wip, wel, op_start, pb_we, pb_clr}), 0);

        // block erase without write enable
        frame(4, 64'hD8034567, 0);
        chk(wip == 0, "R1 erase without write enable", int'(wip), 0);

        // write enable, then accepted block erase at a mid-block address
        frame(1, 64'h06, 0);
        chk(wel == 1, "R9 write enable sets latch", int'(wel), 1);
        frame(4, 64'hD8034567, 0);
        chk(wip == 1, "R5 block erase busy", int'(wip), 1);
        idle(BE_N + 5);
        chk(wip == 0 && wel == 0, "R6 completion clears", int'({wip, wel}), 0);

        // write enable released mid-byte
        frame(1, 64'h06, 4);
        chk(wel == 0, "R2 partial write enable rejected", int'(wel), 0);

        // block erase released mid-byte after a full address
        frame(1, 64'h06, 0);
        frame(3, 64'hD80100, 13);
        chk(wip == 0 && wel == 1, "R2 unaligned erase rejected", int'({wip, wel}), 2'b01);

        // chip erase with a surplus byte
        frame(2, 64'hC700, 0);
        chk(wip == 0, "R2 chip erase length", int'(wip), 0);

        // chip erase with protection
        lock_lvl = 4'd1;
        frame(1, 64'hC7, 0);
        chk(wip == 0, "R4 chip erase locked", int'(wip), 0);
        lock_lvl = 4'd0;

        // chip erase, then commands inside its busy window
        frame(1, 64'hC7, 0);
        chk(wip == 1, "R5 chip erase busy", int'(wip), 1);
        frame(1, 64'h06, 0);
        chk(wel == 1, "R9 write enable while busy", int'(wel), 1);
        frame(5, 64'h02000010AA, 0);
        chk(wip == 1 && pb_q.size() == 0, "R7 program ignored while busy", int'(wip), 1);
        idle(CE_N);
        chk(wip == 0 && wel == 0, "R6 chip erase done", int'({wip, wel}), 0);

        // protected top blocks at level 2
        lock_lvl = 4'd2;
        frame(1, 64'h06, 0);
        frame(4, 64'hD81F0000, 0);
        chk(wip == 0, "R4 top block locked", int'(wip), 0);
        frame(4, 64'hD8051234, 0);
        chk(wip == 1, "R4 low block open", int'(wip), 1);
        idle(BE_N + 5);
        lock_lvl = 4'd0;

        // page program wrapping inside the page
        frame(1, 64'h06, 0);
        frame(7, 64'h020012FE112233, 0);
        chk(wip == 1, "R5 page program busy", int'(wip), 1);
        idle(PP_N + 5);
        chk(pb_q.size() == 0, "R8 all page writes seen", pb_q.size(), 0);

        // page program with no data byte
        frame(1, 64'h06, 0);
        frame(4, 64'h02000000, 0);
        chk(wip == 0, "R2 program without data", int'(wip), 0);

        // page program cut mid-byte: data still streamed, nothing started
        frame(5, 64'h0200000577, 3);
        chk(wip == 0 && wel == 1, "R2 unaligned program", int'({wip, wel}), 2'b01);
        chk(pb_q.size() == 0, "R8 streamed data on rejected frame", pb_q.size(), 0);

        // alternate chip erase opcode
        frame(1, 64'h60, 0);
        chk(wip == 1, "R9 alternate chip erase opcode", int'(wip), 1);
        idle(CE_N + 5);
        chk(wip == 0 && wel == 0, "R6 alternate chip erase done", int'({wip, wel}), 0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule